// File: doc/BRIEF.md
# Bipolar Line Code Decoder

This block turns a dual-rail bipolar line signal into single-rail NRZ data at T1/J1 or E1 rates. Each bit period is marked by a one-cycle `bitEn` strobe. On that strobe the block samples a positive and a negative pulse rail. The matching decoded bit leaves on `dataOut` a fixed eight bit periods later. The delay lets the block see a whole zero-substitution pattern before any of its pulses reach the output.

With `substEn` low, the block decodes plain AMI in either rate mode. With `substEn` high, it removes B8ZS patterns in T1 mode (`e1Mode` low) and HDB3 patterns in E1 mode (`e1Mode` high). Three one-cycle flags report events:
- a recognised substitution;
- a bipolar violation that belongs to no substitution, which is a line code violation;
- a run of line zeros that reaches a threshold set by the rate and coding modes.

Top module: `bipolar_decoder`

## Requirements
- R1: A synchronous reset clears `dataOut`, all three flags, the zero-run count and the polarity reference, so the first mark after reset is never a violation.
- R2: State advances only on cycles with `bitEn` high. The symbol taken on strobe k is decoded onto `dataOut` by strobe k+8, and `dataOut` holds between strobes.
- R3: With `substEn` low, a mark on either rail decodes as 1 and a period with no mark decodes as 0. No pattern is removed and `sigFlag` stays low.
- R4: In T1 mode with `substEn` high, a B8ZS pattern decodes to eight zeros. The pattern is 000VB0VB, where V repeats and B reverses the polarity of the mark before the pattern.
- R5: In E1 mode with `substEn` high, an HDB3 pattern decodes to four zeros. The pattern is either 000V, where V repeats the previous mark's polarity, or B00V, where B reverses it and V equals B.
- R6: `sigFlag` pulses for one clock right after the strobe that carries the last symbol of a recognised pattern.
- R7: A mark that repeats the polarity of the most recent single-rail mark and is not part of a recognised pattern raises `lcvFlag` on the strobe that outputs it. It decodes as 1.
- R8: A period with both rails high raises `lcvFlag` and decodes as 1. It does not change the polarity reference.
- R9: `exzFlag` pulses once when consecutive line zeros reach 4 in E1 mode, 8 in T1 mode with B8ZS, or 16 in T1 mode with AMI. The flag follows the strobe of the zero that completes the run.
- R10: The zero-run count saturates at its maximum and does not wrap, so a long run gives no further `exzFlag` pulse.
- R11: All flags are low in any cycle that does not directly follow a `bitEn` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | One-cycle strobe per bit period |
| posRail | input | 1 | Positive pulse rail |
| negRail | input | 1 | Negative pulse rail |
| e1Mode | input | 1 | 1 = E1 (HDB3), 0 = T1/J1 (B8ZS) |
| substEn | input | 1 | 1 = remove substitutions, 0 = plain AMI |
| dataOut | output | 1 | Decoded NRZ bit, updated on each strobe |
| lcvFlag | output | 1 | Line code violation pulse |
| sigFlag | output | 1 | Substitution recognised pulse |
| exzFlag | output | 1 | Excessive zeros pulse |

## Verification
The assertions assume that `e1Mode` and `substEn` change only while `rst` is high. This matters because the threshold and pattern checks reason about a single mode across the whole eight-symbol window. The stimulus therefore sets both mode inputs together with reset before each sequence. It holds them fixed until the next reset.

The assertions also assume that `bitEn` is never high in two adjacent cycles. The bench keeps to this by placing at least two idle cycles between strobes. Encoded streams start with a mark so that a polarity reference exists before the first pattern arrives.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  // Longest substitution pattern sets the window depth; the short one is the E1 pattern.
  localparam int SIG_LEN = 8;
  localparam int HDB_LEN = 4;

  typedef struct packed {
    logic mark;   // pulse on either rail
    logic pol;    // 1 = positive rail
    logic dual;   // both rails in one period
    logic sub;    // pulse belongs to a recognised pattern
  } sym_t;

  typedef struct packed {
    logic [SIG_LEN-1:0] subMask;
    logic               sigHit;
    logic               exzHit;
  } strobe_t;
endpackage

// File: rtl/bpd_control.sv
module bpd_control
  import bpd_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int ZTHR_E1  = 4,
  parameter int ZTHR_T1B = 8,
  parameter int ZTHR_T1A = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bitEn,
  input  logic                  e1Mode,
  input  logic                  substEn,
  input  sym_t [SIG_LEN:0]      cand,
  input  logic                  refPol,
  input  logic                  refValid,
  output strobe_t               stb
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LAST_E1  = CNT_W'(ZTHR_E1 - 1);
  localparam logic [CNT_W-1:0] LAST_T1B = CNT_W'(ZTHR_T1B - 1);
  localparam logic [CNT_W-1:0] LAST_T1A = CNT_W'(ZTHR_T1A - 1);
  localparam logic [SIG_LEN-1:0] MASK_B8  = SIG_LEN'(8'b0001_1011);
  localparam logic [SIG_LEN-1:0] MASK_H0V = SIG_LEN'(1);
  localparam logic [SIG_LEN-1:0] MASK_HBV = SIG_LEN'((1 << (HDB_LEN - 1)) | 1);

  logic [CNT_W-1:0] zeroCnt;
  logic [CNT_W-1:0] zThrLast;
  logic lineZero;
  logic hdbRef, hdbOk;
  logic b8Ref, b8Ok;
  logic b8Hit, h0vHit, hbvHit;
  logic unusedCand;

  assign unusedCand = ^cand;

  function automatic logic isPulse(sym_t s, logic p);
    return s.mark && !s.dual && !s.sub && (s.pol == p);
  endfunction

  // Polarity of the nearest single-rail mark older than each pattern window.
  always_comb begin
    hdbRef = refPol;
    hdbOk  = refValid;
    for (int i = SIG_LEN; i >= HDB_LEN; i--) begin
      if (cand[i].mark && !cand[i].dual) begin
        hdbRef = cand[i].pol;
        hdbOk  = 1'b1;
      end
    end
    b8Ref = refPol;
    b8Ok  = refValid;
    if (cand[SIG_LEN].mark && !cand[SIG_LEN].dual) begin
      b8Ref = cand[SIG_LEN].pol;
      b8Ok  = 1'b1;
    end
  end

  always_comb begin
    b8Hit = substEn && !e1Mode && b8Ok &&
            !cand[7].mark && !cand[6].mark && !cand[5].mark &&
            isPulse(cand[4], b8Ref) && isPulse(cand[3], !b8Ref) &&
            !cand[2].mark &&
            isPulse(cand[1], !b8Ref) && isPulse(cand[0], b8Ref);
    h0vHit = substEn && e1Mode && hdbOk &&
             !cand[3].mark && !cand[2].mark && !cand[1].mark &&
             isPulse(cand[0], hdbRef);
    hbvHit = substEn && e1Mode && hdbOk &&
             isPulse(cand[3], !hdbRef) && !cand[2].mark && !cand[1].mark &&
             isPulse(cand[0], !hdbRef);
  end

  assign lineZero = !cand[0].mark;
  assign zThrLast = e1Mode ? LAST_E1 : (substEn ? LAST_T1B : LAST_T1A);

  always_comb begin
    stb.subMask = '0;
    if (b8Hit)  stb.subMask = MASK_B8;
    if (h0vHit) stb.subMask = MASK_H0V;
    if (hbvHit) stb.subMask = MASK_HBV;
    stb.sigHit = b8Hit || h0vHit || hbvHit;
    stb.exzHit = lineZero && (zeroCnt == zThrLast);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zeroCnt <= '0;
    end else if (bitEn) begin
      if (!lineZero)                zeroCnt <= '0;
      else if (zeroCnt != CNT_MAX)  zeroCnt <= zeroCnt + 1'b1;
    end
  end

  assert_sub_needs_coding_R3: assert property (@(posedge clk) disable iff (rst)
    (bitEn && (|stb.subMask)) |-> substEn);
  assert_b8zs_four_marks_R4: assert property (@(posedge clk) disable iff (rst)
    (bitEn && stb.sigHit && !e1Mode) |-> ($countones(stb.subMask) == 4));
  assert_hdb3_marks_R5: assert property (@(posedge clk) disable iff (rst)
    (bitEn && stb.sigHit && e1Mode) |->
      (stb.subMask[0] && ($countones(stb.subMask) == 1 || $countones(stb.subMask) == 2)));
  assert_mark_clears_run_R9: assert property (@(posedge clk) disable iff (rst)
    (bitEn && !lineZero) |=> (zeroCnt == '0));
  assert_zero_cnt_sat_R10: assert property (@(posedge clk) disable iff (rst)
    (bitEn && lineZero && zeroCnt == CNT_MAX) |=> (zeroCnt == CNT_MAX));
endmodule

// File: rtl/bpd_datapath.sv
module bpd_datapath
  import bpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              posRail,
  input  logic              negRail,
  input  strobe_t           stb,
  output sym_t [SIG_LEN:0]  cand,
  output logic              refPol,
  output logic              refValid,
  output logic              dataOut,
  output logic              lcvFlag,
  output logic              sigFlag,
  output logic              exzFlag
);
  sym_t [SIG_LEN-1:0] pipe;
  sym_t [SIG_LEN-1:0] nextPipe;
  sym_t inSym;
  sym_t exitSym;
  logic lastPol, polValid;
  logic exitViol;

  always_comb begin
    inSym.mark = posRail | negRail;
    inSym.pol  = posRail;
    inSym.dual = posRail & negRail;
    inSym.sub  = 1'b0;
  end

  assign exitSym = pipe[SIG_LEN-1];

  // Candidate window: incoming symbol at 0, the symbol about to leave at SIG_LEN.
  always_comb begin
    cand[0] = inSym;
    for (int i = 1; i <= SIG_LEN; i++) cand[i] = pipe[i-1];
  end

  always_comb begin
    for (int i = 0; i < SIG_LEN; i++) begin
      nextPipe[i]     = cand[i];
      nextPipe[i].sub = cand[i].sub | stb.subMask[i];
    end
  end

  assign exitViol = exitSym.mark && !exitSym.sub &&
                    (exitSym.dual || (polValid && exitSym.pol == lastPol));
  assign refPol   = lastPol;
  assign refValid = polValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= '0;
      lastPol  <= 1'b0;
      polValid <= 1'b0;
      dataOut  <= 1'b0;
      lcvFlag  <= 1'b0;
      sigFlag  <= 1'b0;
      exzFlag  <= 1'b0;
    end else if (bitEn) begin
      pipe    <= nextPipe;
      dataOut <= exitSym.mark && !exitSym.sub;
      lcvFlag <= exitViol;
      sigFlag <= stb.sigHit;
      exzFlag <= stb.exzHit;
      if (exitSym.mark && !exitSym.dual) begin
        lastPol  <= exitSym.pol;
        polValid <= 1'b1;
      end
    end else begin
      lcvFlag <= 1'b0;
      sigFlag <= 1'b0;
      exzFlag <= 1'b0;
    end
  end

  assert_ref_cleared_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !polValid);
  assert_viol_decodes_one_R7: assert property (@(posedge clk) disable iff (rst)
    lcvFlag |-> dataOut);
  assert_dual_keeps_ref_R8: assert property (@(posedge clk) disable iff (rst)
    (bitEn && exitSym.dual) |=> $stable(lastPol));
  assert_flags_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(bitEn) |-> !(lcvFlag || sigFlag || exzFlag));
endmodule

// File: rtl/bipolar_decoder.sv
module bipolar_decoder
  import bpd_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int ZTHR_E1  = 4,
  parameter int ZTHR_T1B = 8,
  parameter int ZTHR_T1A = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bitEn,
  input  logic posRail,
  input  logic negRail,
  input  logic e1Mode,
  input  logic substEn,
  output logic dataOut,
  output logic lcvFlag,
  output logic sigFlag,
  output logic exzFlag
);
  strobe_t          stb;
  sym_t [SIG_LEN:0] cand;
  logic             refPol, refValid;

  bpd_datapath u_dp (
    .clk(clk), .rst(rst), .bitEn(bitEn), .posRail(posRail), .negRail(negRail),
    .stb(stb), .cand(cand), .refPol(refPol), .refValid(refValid),
    .dataOut(dataOut), .lcvFlag(lcvFlag), .sigFlag(sigFlag), .exzFlag(exzFlag)
  );

  bpd_control #(
    .CNT_W(CNT_W), .ZTHR_E1(ZTHR_E1), .ZTHR_T1B(ZTHR_T1B), .ZTHR_T1A(ZTHR_T1A)
  ) u_ctl (
    .clk(clk), .rst(rst), .bitEn(bitEn), .e1Mode(e1Mode), .substEn(substEn),
    .cand(cand), .refPol(refPol), .refValid(refValid), .stb(stb)
  );
endmodule

// File: tb/sim_bipolar_decoder.sv
`timescale 1ns/1ps
module sim_bipolar_decoder;
  localparam int MAXL = 512;
  localparam int SAT  = 31;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitEn = 1'b0, posRail = 1'b0, negRail = 1'b0;
  logic e1Mode = 1'b0, substEn = 1'b0;
  logic dataOut, lcvFlag, sigFlag, exzFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  bit sp[MAXL], sn[MAXL], ed[MAXL], el[MAXL], es[MAXL], dat[MAXL];
  int seqLen;

  always #10 clk = ~clk;

  bipolar_decoder u0 (
    .clk(clk), .rst(rst), .bitEn(bitEn), .posRail(posRail), .negRail(negRail),
    .e1Mode(e1Mode), .substEn(substEn), .dataOut(dataOut),
    .lcvFlag(lcvFlag), .sigFlag(sigFlag), .exzFlag(exzFlag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doReset(input bit e1, input bit sub);
    @(negedge clk);
    rst = 1'b1; e1Mode = e1; substEn = sub; bitEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sendSym(input bit p, input bit n);
    @(negedge clk);
    posRail = p; negRail = n; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0; posRail = 1'b0; negRail = 1'b0;
  endtask

  task automatic clearArr();
    for (int k = 0; k < MAXL; k++) begin
      sp[k] = 0; sn[k] = 0; ed[k] = 0; el[k] = 0; es[k] = 0; dat[k] = 0;
    end
  endtask

  task automatic put(input int idx, input bit pol);
    sp[idx] = pol; sn[idx] = !pol;
  endtask

  task automatic setSym(input int idx, input bit p, input bit n, input bit d, input bit l);
    sp[idx] = p; sn[idx] = n; ed[idx] = d; el[idx] = l;
  endtask

  function automatic bit allZero(input int from, input int cnt);
    for (int k = from; k < from + cnt; k++) if (dat[k]) return 0;
    return 1;
  endfunction

  // Random data with zero runs up to 20, encoded by the line code rules.
  task automatic buildCoded(input bit e1, input bit sub, input int len);
    int idx, i, marks;
    bit last;
    clearArr();
    seqLen = len;
    dat[0] = 1; idx = 1;
    while (idx < len) begin
      idx += $urandom_range(0, 20);
      if (idx < len) dat[idx] = 1;
      idx++;
    end
    for (int k = 0; k < len; k++) ed[k] = dat[k];
    i = 0; marks = 0; last = 0;
    while (i < len) begin
      if (sub && !e1 && i + 7 < len && allZero(i, 8)) begin
        put(i+3, last); put(i+4, !last); put(i+6, !last); put(i+7, last);
        es[i+7] = 1; i += 8;
      end else if (sub && e1 && i + 3 < len && allZero(i, 4)) begin
        if (marks % 2 == 1) put(i+3, last);
        else begin put(i, !last); put(i+3, !last); last = !last; end
        es[i+3] = 1; marks = 0; i += 4;
      end else begin
        if (dat[i]) begin last = !last; put(i, last); marks++; end
        i++;
      end
    end
  endtask

  // Random raw symbols for AMI decoding, expected violations from the polarity rule.
  task automatic buildRandom(input int len);
    bit last, valid, p, n;
    int r;
    clearArr();
    seqLen = len; last = 0; valid = 0;
    for (int k = 0; k < len; k++) begin
      r = $urandom_range(0, 9);
      p = (r == 2 || r == 3 || r == 9 || (r == 4 && !last));
      n = (r == 5 || r == 6 || r == 9 || (r == 4 && last));
      sp[k] = p; sn[k] = n; ed[k] = p | n;
      el[k] = (p & n) | ((p ^ n) & valid & (p == last));
      if (p ^ n) begin last = p; valid = 1; end
    end
  endtask

  task automatic runSeq(input bit e1, input bit sub, input string dTag,
                        input string lTag, input string eTag);
    int run, thr;
    bit p, n, zero, expZ, held;
    doReset(e1, sub);
    run = 0;
    thr = e1 ? 4 : (sub ? 8 : 16);
    for (int k = 0; k < seqLen + 8; k++) begin
      p = (k < seqLen) ? sp[k] : 1'b0;
      n = (k < seqLen) ? sn[k] : 1'b0;
      sendSym(p, n);
      zero = !(p | n);
      expZ = zero && (run == thr - 1);
      run = zero ? ((run == SAT) ? SAT : run + 1) : 0;
      chk(eTag, $sformatf("exzFlag at symbol %0d", k), exzFlag, expZ);
      chk("R6", $sformatf("sigFlag at symbol %0d", k), sigFlag, (k < seqLen) ? es[k] : 0);
      if (k >= 8) begin
        chk(dTag, $sformatf("dataOut for bit %0d", k-8), dataOut, ed[k-8]);
        chk(lTag, $sformatf("lcvFlag for bit %0d", k-8), lcvFlag, el[k-8]);
      end
      held = dataOut;
      @(negedge clk);
      chk("R2", "dataOut held between strobes", dataOut, held);
      chk("R11", "flags low off strobe", {lcvFlag, sigFlag, exzFlag}, 0);
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL R11 watchdog: got 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    doReset(1'b0, 1'b0);
    chk("R1", "dataOut after reset", dataOut, 0);
    chk("R1", "lcvFlag after reset", lcvFlag, 0);
    chk("R1", "sigFlag after reset", sigFlag, 0);
    chk("R1", "exzFlag after reset", exzFlag, 0);

    // Encoded streams in each mode pair.
    buildCoded(1'b0, 1'b1, 400); runSeq(1'b0, 1'b1, "R4", "R7", "R9");
    buildCoded(1'b1, 1'b1, 400); runSeq(1'b1, 1'b1, "R5", "R7", "R9");
    buildCoded(1'b0, 1'b0, 400); runSeq(1'b0, 1'b0, "R3", "R7", "R9");
    buildCoded(1'b1, 1'b0, 400); runSeq(1'b1, 1'b0, "R3", "R7", "R9");

    // Random raw symbols, AMI in both rates; first mark after reset is never a violation (R1).
    buildRandom(300); runSeq(1'b0, 1'b0, "R3", "R1", "R9");
    buildRandom(300); runSeq(1'b1, 1'b0, "R8", "R7", "R9");

    // R3: a B8ZS-shaped pattern in AMI mode decodes as marks with violations.
    clearArr(); seqLen = 9;
    setSym(0,1,0,1,0); setSym(4,1,0,1,1); setSym(5,0,1,1,0);
    setSym(7,0,1,1,1); setSym(8,1,0,1,0);
    runSeq(1'b0, 1'b0, "R3", "R3", "R9");

    // R7: repeated polarity in HDB3 mode outside any pattern.
    clearArr(); seqLen = 5;
    setSym(0,1,0,1,0); setSym(1,0,1,1,0); setSym(2,0,1,1,1); setSym(4,1,0,1,0);
    runSeq(1'b1, 1'b1, "R7", "R7", "R9");

    // R8: dual-rail periods flag and leave the polarity reference alone.
    clearArr(); seqLen = 6;
    setSym(0,0,1,1,0); setSym(1,1,1,1,1); setSym(2,1,0,1,0);
    setSym(4,1,1,1,1); setSym(5,1,0,1,1);
    runSeq(1'b0, 1'b1, "R8", "R8", "R9");

    // R10: 40 zeros in T1 AMI give one pulse at the sixteenth zero.
    clearArr(); seqLen = 42;
    setSym(0,1,0,1,0); setSym(41,0,1,1,0);
    runSeq(1'b0, 1'b0, "R3", "R7", "R10");

    // R9: eight-zero threshold in T1 B8ZS and four-zero threshold in E1 on raw lines.
    clearArr(); seqLen = 12;
    setSym(0,1,0,1,0); setSym(11,0,1,1,0);
    runSeq(1'b0, 1'b1, "R4", "R7", "R9");
    clearArr(); seqLen = 6;
    setSym(0,1,0,1,0); setSym(5,0,1,1,0);
    runSeq(1'b1, 1'b1, "R5", "R7", "R9");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule